// File: doc/BRIEF.md
# Sensor-Style Raster Timing Generator

This block produces the parallel video stream a camera front end would emit: a 12-bit pixel word together with a frame strobe and a line strobe, all timed by one pixel clock. The active window, the horizontal gap between lines and the vertical gap between frames are parameters (1280 by 960 active pixels by default). The frame strobe opens a fixed number of clocks ahead of the first line and closes a fixed number of clocks after the last line, so a receiver can arm itself before data arrives.

Instead of image content, the block fills the active window with one of several debug patterns chosen by a 3-bit code: a diagonal ramp, a constant level from an input, eight vertical bars, a column fade and a walking single bit. It either streams frames back to back while enabled, or, in trigger mode, emits exactly one frame per rising edge of a trigger input. A parameter selects whether the outputs are launched on the rising or the falling clock edge, so the receiver can capture on the opposite edge.

Top module: `raster_gen`

## Requirements
- R1: While reset is held, and afterwards while neither streaming nor a trigger has started a frame, the frame strobe, the line strobe and the pixel word are all zero.
- R2: The frame strobe goes high exactly FV_LEAD clocks (default 6) before the line strobe goes high for the first line of the frame.
- R3: The frame strobe goes low exactly FV_TRAIL clocks (default 6) after the line strobe goes low at the end of the last line.
- R4: Each frame holds V_ACTIVE lines, each a run of H_ACTIVE consecutive clocks with the line strobe high, consecutive lines separated by exactly H_BLANK clocks with it low; the line strobe is never high while the frame strobe is low.
- R5: Within a line, with x the column (0 first) and y the line (0 first): code 0 outputs (x + y) mod 4096, code 1 outputs the 12-bit solid level input, code 3 outputs x mod 4096, and codes 5, 6 and 7 output zero.
- R6: Code 2 splits the line into eight bars of H_ACTIVE/8 columns; bar b (0 at the left) outputs b × 585, so the bars run from 0 to 4095.
- R7: Code 4 outputs a word with only bit (x mod 12) set, so the bit moves one place toward the MSB per pixel and wraps from bit 11 to bit 0.
- R8: The pixel word is zero on every clock on which the line strobe is low.
- R9: In continuous mode with streaming held on, the frame strobe stays low for exactly V_BLANK × (H_ACTIVE + H_BLANK) clocks between frames.
- R10: Clearing the streaming enable during a frame lets that frame finish with all its lines; no further frame starts while it stays clear.
- R11: In trigger mode the streaming enable has no effect; a rising trigger edge while idle produces exactly one frame, and a trigger edge during a frame starts nothing further.
- R12: With LAUNCH_NEG = 1 all outputs change on the falling clock edge and carry, half a clock earlier, the values the rising-edge build shows after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stream_en | input | 1 | Continuous-mode run enable, checked only between frames |
| trig_mode | input | 1 | 1 selects single-frame trigger mode, 0 continuous mode |
| trig_in | input | 1 | Frame trigger, acts on its rising edge while idle |
| pat_sel | input | 3 | Test pattern code |
| solid_val | input | 12 | Level for the solid pattern |
| fv_o | output | 1 | Frame strobe |
| lv_o | output | 1 | Line strobe |
| pix_o | output | 12 | Pixel word |

## Verification
The bench builds the generator with a 32-pixel by 3-line window, 5 blank clocks per line and 2 blank lines per frame, keeping the default lead and trail of 6 and 12-bit data. With 32 columns the bars are four pixels wide and the walking bit wraps past bit 11 twice per line, so every pattern, every frame edge and the inter-frame gap are checked pixel by pixel in full frames of about 120 clocks. A second instance with falling-edge launch runs from the same inputs and is compared against the first cycle by cycle.

// File: rtl/raster_pkg.sv
package raster_pkg;

   typedef enum logic [2:0] {
      PAT_RAMP  = 3'd0,
      PAT_SOLID = 3'd1,
      PAT_BARS  = 3'd2,
      PAT_FADE  = 3'd3,
      PAT_WALK  = 3'd4
   } pat_e;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_LEAD   = 3'd1,
      PH_ACTIVE = 3'd2,
      PH_TRAIL  = 3'd3,
      PH_VGAP   = 3'd4
   } phase_e;

   localparam int unsigned NUM_BARS = 8;

endpackage

// File: rtl/raster_timing.sv
module raster_timing
   import raster_pkg::*;
#(
   parameter int unsigned H_ACTIVE = 1280,
   parameter int unsigned V_ACTIVE = 960,
   parameter int unsigned H_BLANK  = 208,
   parameter int unsigned V_BLANK  = 40,
   parameter int unsigned FV_LEAD  = 6,
   parameter int unsigned FV_TRAIL = 6,
   parameter int unsigned XW       = 11,
   parameter int unsigned YW       = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stream_en,
   input  logic          trig_mode,
   input  logic          trig_in,
   output logic          fv_pre,
   output logic          lv_pre,
   output logic [XW-1:0] col,
   output logic [YW-1:0] row
);

   localparam int unsigned LINE    = H_ACTIVE + H_BLANK;
   localparam int unsigned VG_CLKS = V_BLANK * LINE;
   localparam int unsigned CW      = $clog2(VG_CLKS + FV_LEAD + FV_TRAIL + 1);

   phase_e        phase;
   logic [XW-1:0] h_q;
   logic [YW-1:0] v_q;
   logic [CW-1:0] cnt_q;
   logic          trig_q;
   logic          trig_rise;
   logic          last_pix;

   assign trig_rise = trig_in & ~trig_q;
   assign last_pix  = (v_q == YW'(V_ACTIVE - 1)) && (h_q == XW'(H_ACTIVE - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         h_q    <= '0;
         v_q    <= '0;
         cnt_q  <= '0;
         trig_q <= 1'b0;
      end else begin
         trig_q <= trig_in;
         unique case (phase)
            PH_IDLE: begin
               if (trig_mode ? trig_rise : stream_en) begin
                  phase <= PH_LEAD;
                  cnt_q <= '0;
               end
            end
            PH_LEAD: begin
               if (cnt_q == CW'(FV_LEAD - 1)) begin
                  phase <= PH_ACTIVE;
                  h_q   <= '0;
                  v_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_ACTIVE: begin
               if (last_pix) begin
                  phase <= PH_TRAIL;
                  cnt_q <= '0;
               end else if (h_q == XW'(LINE - 1)) begin
                  h_q <= '0;
                  v_q <= v_q + 1'b1;
               end else begin
                  h_q <= h_q + 1'b1;
               end
            end
            PH_TRAIL: begin
               if (cnt_q == CW'(FV_TRAIL - 1)) begin
                  phase <= PH_VGAP;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_VGAP: begin
               if (cnt_q == CW'(VG_CLKS - 1)) begin
                  cnt_q <= '0;
                  phase <= (!trig_mode && stream_en) ? PH_LEAD : PH_IDLE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign fv_pre = (phase == PH_LEAD) || (phase == PH_ACTIVE) || (phase == PH_TRAIL);
   assign lv_pre = (phase == PH_ACTIVE) && (h_q < XW'(H_ACTIVE));
   assign col    = h_q;
   assign row    = v_q;

   // Column counter never runs past the end of a line period.
   assert_col_in_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ACTIVE) |-> (h_q < XW'(LINE)));

   // Once lines are flowing, the frame can only continue or enter its trail.
   assert_frame_runs_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ACTIVE) |=> (phase == PH_ACTIVE || phase == PH_TRAIL));

   // In trigger mode the vertical gap never chains straight into a new frame.
   assert_trig_no_chain_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_VGAP && trig_mode) |=> (phase != PH_LEAD));

endmodule

// File: rtl/raster_pattern.sv
module raster_pattern
   import raster_pkg::*;
#(
   parameter int unsigned DATA_W   = 12,
   parameter int unsigned H_ACTIVE = 1280,
   parameter int unsigned XW       = 11,
   parameter int unsigned YW       = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        sel,
   input  logic [DATA_W-1:0] solid,
   input  logic [XW-1:0]     col,
   input  logic [YW-1:0]     row,
   input  logic              line_on,
   output logic [DATA_W-1:0] data
);

   localparam int unsigned BAR_W    = H_ACTIVE / NUM_BARS;
   localparam int unsigned BAR_STEP = ((2 ** DATA_W) - 1) / (NUM_BARS - 1);

   logic [2:0]        bar_idx;
   logic [DATA_W-1:0] raw;

   assign bar_idx = 3'(32'(col) / BAR_W);

   always_comb begin
      unique case (sel)
         PAT_RAMP:  raw = DATA_W'(col) + DATA_W'(row);
         PAT_SOLID: raw = solid;
         PAT_BARS:  raw = DATA_W'(32'(bar_idx) * BAR_STEP);
         PAT_FADE:  raw = DATA_W'(col);
         PAT_WALK:  raw = DATA_W'(1) << (32'(col) % DATA_W);
         default:   raw = '0;
      endcase
      data = line_on ? raw : '0;
   end

   // Walking-bit word carries exactly one set bit inside a line.
   assert_walk_single_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (line_on && sel == PAT_WALK) |-> $onehot(data));

endmodule

// File: rtl/raster_gen.sv
module raster_gen
   import raster_pkg::*;
#(
   parameter int unsigned DATA_W     = 12,
   parameter int unsigned H_ACTIVE   = 1280,
   parameter int unsigned V_ACTIVE   = 960,
   parameter int unsigned H_BLANK    = 208,
   parameter int unsigned V_BLANK    = 40,
   parameter int unsigned FV_LEAD    = 6,
   parameter int unsigned FV_TRAIL   = 6,
   parameter bit          LAUNCH_NEG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stream_en,
   input  logic              trig_mode,
   input  logic              trig_in,
   input  logic [2:0]        pat_sel,
   input  logic [DATA_W-1:0] solid_val,
   output logic              fv_o,
   output logic              lv_o,
   output logic [DATA_W-1:0] pix_o
);

   localparam int unsigned XW = $clog2(H_ACTIVE + H_BLANK);
   localparam int unsigned YW = $clog2(V_ACTIVE + 1);

   if (H_ACTIVE % NUM_BARS != 0 || H_ACTIVE < NUM_BARS) begin : g_chk_width
      $error("H_ACTIVE must be a nonzero multiple of the bar count");
   end
   if (FV_LEAD < 1 || FV_TRAIL < 1) begin : g_chk_edges
      $error("FV_LEAD and FV_TRAIL must be at least 1");
   end
   if (H_BLANK < 1 || V_BLANK < 1 || V_ACTIVE < 1) begin : g_chk_blank
      $error("blanking and line count must be at least 1");
   end
   if (DATA_W < 4) begin : g_chk_data
      $error("DATA_W must be at least 4");
   end

   logic              fv_pre;
   logic              lv_pre;
   logic [XW-1:0]     col;
   logic [YW-1:0]     row;
   logic [DATA_W-1:0] pix_pre;

   raster_timing #(
      .H_ACTIVE (H_ACTIVE),
      .V_ACTIVE (V_ACTIVE),
      .H_BLANK  (H_BLANK),
      .V_BLANK  (V_BLANK),
      .FV_LEAD  (FV_LEAD),
      .FV_TRAIL (FV_TRAIL),
      .XW       (XW),
      .YW       (YW)
   ) u_timing (
      .clk       (clk),
      .rst_n     (rst_n),
      .stream_en (stream_en),
      .trig_mode (trig_mode),
      .trig_in   (trig_in),
      .fv_pre    (fv_pre),
      .lv_pre    (lv_pre),
      .col       (col),
      .row       (row)
   );

   raster_pattern #(
      .DATA_W   (DATA_W),
      .H_ACTIVE (H_ACTIVE),
      .XW       (XW),
      .YW       (YW)
   ) u_pattern (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (pat_sel),
      .solid   (solid_val),
      .col     (col),
      .row     (row),
      .line_on (lv_pre),
      .data    (pix_pre)
   );

   if (LAUNCH_NEG) begin : g_launch_fall
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fv_o  <= 1'b0;
            lv_o  <= 1'b0;
            pix_o <= '0;
         end else begin
            fv_o  <= fv_pre;
            lv_o  <= lv_pre;
            pix_o <= pix_pre;
         end
      end
   end else begin : g_launch_rise
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fv_o  <= 1'b0;
            lv_o  <= 1'b0;
            pix_o <= '0;
         end else begin
            fv_o  <= fv_pre;
            lv_o  <= lv_pre;
            pix_o <= pix_pre;
         end
      end
   end

   assert_line_inside_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lv_o |-> fv_o);

   assert_blank_is_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !lv_o |-> (pix_o == '0));

endmodule

// File: tb/sim_raster_gen.sv
module sim_raster_gen;

   localparam int HA   = 32;
   localparam int VA   = 3;
   localparam int HB   = 5;
   localparam int VB   = 2;
   localparam int LEAD = 6;
   localparam int TRL  = 6;
   localparam int GAP  = VB * (HA + HB);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stream_en = 1'b0;
   logic        trig_mode = 1'b0;
   logic        trig_in = 1'b0;
   logic [2:0]  pat_sel = 3'd0;
   logic [11:0] solid_val = 12'h000;
   logic        fv0, lv0, fv1, lv1;
   logic [11:0] pix0, pix1;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   raster_gen #(.DATA_W(12), .H_ACTIVE(HA), .V_ACTIVE(VA), .H_BLANK(HB), .V_BLANK(VB),
                .FV_LEAD(LEAD), .FV_TRAIL(TRL), .LAUNCH_NEG(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .stream_en(stream_en), .trig_mode(trig_mode),
      .trig_in(trig_in), .pat_sel(pat_sel), .solid_val(solid_val),
      .fv_o(fv0), .lv_o(lv0), .pix_o(pix0));

   raster_gen #(.DATA_W(12), .H_ACTIVE(HA), .V_ACTIVE(VA), .H_BLANK(HB), .V_BLANK(VB),
                .FV_LEAD(LEAD), .FV_TRAIL(TRL), .LAUNCH_NEG(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .stream_en(stream_en), .trig_mode(trig_mode),
      .trig_in(trig_in), .pat_sel(pat_sel), .solid_val(solid_val),
      .fv_o(fv1), .lv_o(lv1), .pix_o(pix1));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #5;
   endtask

   function automatic int exp_pix(input int sel, input int x, input int y, input int solid);
      case (sel)
         0: return (x + y) % 4096;
         1: return solid;
         2: return (x / (HA / 8)) * 585;
         3: return x % 4096;
         4: return 1 << (x % 12);
         default: return 0;
      endcase
   endfunction

   // Follows one frame from the first clock of the frame strobe to its fall.
   task automatic run_frame(input int sel, input string req, input int stop_at, input int trig_at);
      int waitc = 0;
      int lead = 0, gap = 0, lines = 0, x = 0, n = 0;
      int bad_w = 0, bad_gap = 0, bad_data = 0, bad_gate = 0;
      bit prev_lv = 1'b0;
      while (!fv0 && waitc < 3000) begin
         step();
         waitc++;
      end
      chk(fv0 == 1'b1, "R2 frame start", int'(fv0), 1);
      while (fv0 && n < 3000) begin
         if (n == stop_at) stream_en = 1'b0;
         if (n == trig_at) trig_in = 1'b1;
         if (n == trig_at + 2) trig_in = 1'b0;
         if (lv0) begin
            if (!prev_lv) begin
               if (lines > 0 && gap != HB) bad_gap++;
               lines++;
               x = 0;
            end
            if (int'(pix0) != exp_pix(sel, x, lines - 1, int'(solid_val))) bad_data++;
            x++;
         end else begin
            if (prev_lv) begin
               if (x != HA) bad_w++;
               gap = 0;
            end
            if (lines == 0) lead++;
            else gap++;
            if (pix0 != 12'd0) bad_gate++;
         end
         prev_lv = lv0;
         n++;
         step();
      end
      if (lv0 || pix0 != 12'd0) bad_gate++;
      chk(lead == LEAD, "R2 lead clocks", lead, LEAD);
      chk(!prev_lv && gap == TRL, "R3 trail clocks", gap, TRL);
      chk(lines == VA && bad_w == 0 && bad_gap == 0, "R4 line structure", lines, VA);
      chk(bad_data == 0, req, bad_data, 0);
      chk(bad_gate == 0, "R8 blank data zero", bad_gate, 0);
   endtask

   task automatic measure_gap(input int next_sel);
      int g = 0;
      pat_sel = 3'(next_sel);
      while (!fv0 && g < 3000) begin
         step();
         g++;
      end
      chk(g == GAP, "R9 vertical gap", g, GAP);
   endtask

   task automatic quiet(input int cycles, input string req);
      int seen = 0;
      for (int i = 0; i < cycles; i++) begin
         if (fv0 || lv0 || pix0 != 12'd0) seen++;
         step();
      end
      chk(seen == 0, req, seen, 0);
   endtask

   task automatic t_reset();
      int bad = 0;
      for (int i = 0; i < 4; i++) begin
         step();
         if (fv0 || lv0 || pix0 != 12'd0 || fv1 || lv1 || pix1 != 12'd0) bad++;
      end
      chk(bad == 0, "R1 outputs in reset", bad, 0);
      rst_n = 1'b1;
      quiet(40, "R1 idle after reset");
   endtask

   task automatic t_master_patterns();
      pat_sel = 3'd0;
      stream_en = 1'b1;
      run_frame(0, "R5 ramp data", -1, -1);
      measure_gap(2);
      run_frame(2, "R6 bar data", -1, -1);
      measure_gap(4);
      run_frame(4, "R7 walking one", -1, -1);
      solid_val = 12'hA5C;
      measure_gap(1);
      run_frame(1, "R5 solid data", -1, -1);
      measure_gap(3);
      run_frame(3, "R5 fade data", -1, -1);
      measure_gap(6);
      run_frame(6, "R5 unused code zero", -1, -1);
   endtask

   task automatic t_stop_midframe();
      pat_sel = 3'd0;
      run_frame(0, "R10 frame finishes", 40, -1);
      quiet(300, "R10 no frame after stop");
   endtask

   task automatic t_trigger();
      trig_mode = 1'b1;
      stream_en = 1'b1;
      pat_sel = 3'd3;
      quiet(200, "R11 no frame without trigger");
      trig_in = 1'b1;
      step();
      step();
      trig_in = 1'b0;
      run_frame(3, "R11 triggered frame data", -1, 30);
      quiet(300, "R11 single frame per trigger");
      trig_mode = 1'b0;
      stream_en = 1'b0;
   endtask

   task automatic t_launch_edge();
      int bad = 0, active = 0;
      logic        f1, l1;
      logic [11:0] p1;
      stream_en = 1'b1;
      pat_sel = 3'd4;
      step();
      for (int i = 0; i < 400; i++) begin
         #10;
         f1 = fv1; l1 = lv1; p1 = pix1;
         step();
         if (f1 != fv0 || l1 != lv0 || p1 != pix0) bad++;
         if (l1) active++;
      end
      chk(bad == 0, "R12 falling-edge launch leads", bad, 0);
      chk(active > 0, "R12 falling-edge build streams", active, 1);
      stream_en = 1'b0;
   endtask

   initial begin
      t_reset();
      t_master_patterns();
      t_stop_midframe();
      t_trigger();
      t_launch_edge();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule